// File: doc/BRIEF.md
# Nibble-Direction Bidirectional Port Controller

This block controls an 8-pin bidirectional port that is reached through a small register bus. It holds a data latch and a mode byte. From these it drives a registered output value, output enable, open-drain flag and pull-up enable for each pin toward the pad ring. Pad inputs are brought back through a two-stage synchronizer so that software can read them.

Direction is chosen for each group of four pins, not for each pin. A single mode bit switches every driver on the port between push-pull and open-drain. The highest pin can carry a serial transmit bit from an external UART in place of the data latch. That bit reaches the pad only when the upper group is set as output. A stop-recovery pulse returns both groups to input without losing the other settings.

Top module: `nibble_gpio_port`

## Requirements
- R1: While `rst` is high at a clock edge, the data latch clears and the mode byte loads 0x60. After that edge, `pad_oe`, `pad_out`, `pad_od` and `pad_pu` are all zero.
- R2: Mode bit 5 sets the direction of pins 3..0 and mode bit 6 sets the direction of pins 7..4, where 0 means output. In push-pull mode, every pin of an output group has `pad_oe` high and every pin of an input group has it low.
- R3: Mode bit 2 selects the driver type for all pins at once: 0 is push-pull and 1 is open-drain. `pad_od` shows that bit on every pin. In open-drain mode `pad_out` is 0 on every pin. An output pin then has `pad_oe` high only when its value is 0, so a value of 1 releases the pin.
- R4: In push-pull mode, `pad_out` carries the pin value whatever the direction. The pin value is the data latch bit, except where R5 applies.
- R5: When `uart_tx_en` is 1, the value of pin 7 is taken from `uart_txd` instead of the data latch. It appears on the pad outputs one clock after it is sampled.
- R6: When the upper group is set as input, `pad_oe[7]` stays 0 even when `uart_tx_en` is 1, so the transmit bit is not driven onto the pin.
- R7: A `stop_recover` pulse forces mode bits 6 and 5 to 1. The other mode bits and the data latch keep their values. If a mode write falls in the same cycle, the write sets the other bits and the direction bits still end up as inputs.
- R8: A read with `reg_sel`=0 returns the data latch bit for pins in output groups and the synchronized pad input for pins in input groups. A pad change shows up in the read two clocks after it is sampled. Pin 7 returns its latch bit even while the UART owns it.
- R9: A write to the data latch while its group is set as input is kept. The value appears on the pad as soon as the group is switched to output.
- R10: `pad_pu` gives each pin the pull-up bit of its group from `pullup_cfg`, where bit 0 covers pins 3..0 and bit 1 covers pins 7..4. It is registered with a latency of one clock.
- R11: When `reg_we` is high at a clock edge, `reg_wdata` is written to the data latch if `reg_sel`=0 and to the mode byte if `reg_sel`=1. `reg_rdata` depends combinationally on `reg_sel`, and `reg_sel`=1 returns the stored mode byte. The pad outputs follow a register change one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_recover | input | 1 | Stop-recovery pulse; returns both groups to input |
| reg_we | input | 1 | Single-cycle write strobe |
| reg_sel | input | 1 | Register select: 0 data latch, 1 mode byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for the selected register |
| uart_tx_en | input | 1 | UART transmit enable |
| uart_txd | input | 1 | UART serial transmit bit |
| pullup_cfg | input | 2 | Static pull-up selection per group |
| pad_in | input | 8 | Asynchronous pad input values |
| pad_out | output | 8 | Output value per pin |
| pad_oe | output | 8 | Output enable per pin |
| pad_od | output | 8 | Open-drain select per pin |
| pad_pu | output | 8 | Pull-up enable per pin |

## Verification
The two functions that can land on the same clock edge are a software write to the mode byte and a stop-recovery pulse. They collide on the direction bits. The bench raises `reg_we` with `reg_sel`=1 in the same cycle as `stop_recover` and writes a value that asks for both groups as output together with open-drain. It then checks that the mode byte reads back with the written open-drain bit and both direction bits set, and that one clock later `pad_oe` is zero while `pad_od` is all ones.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_MODE = 1'b1
  } reg_sel_e;

  localparam int GROUP_W = 4;
  localparam int OD_BIT  = 2;
  localparam int DIR_LSB = 5;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int NGRP  = WIDTH / GROUP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_recover,
  input  logic             we,
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] mode_q
);
  // direction bits set = every group an input
  localparam logic [WIDTH-1:0] DIR_MASK =
    {{(WIDTH-NGRP){1'b0}}, {NGRP{1'b1}}} << DIR_LSB;

  logic             mode_wr;
  logic [WIDTH-1:0] mode_nx;

  assign mode_wr = we && (sel == SEL_MODE);

  always_comb begin
    mode_nx = mode_wr ? wdata : mode_q;
    if (stop_recover) begin
      mode_nx = mode_nx | DIR_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      mode_q <= DIR_MASK;
    end else begin
      if (we && (sel == SEL_DATA)) begin
        data_q <= wdata;
      end
      mode_q <= mode_nx;
    end
  end
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= (s == 0) ? d : stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_drive.sv
module gpio_port_drive
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int NGRP  = WIDTH / GROUP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] data_q,
  input  logic [NGRP-1:0]  grp_in,      // 1 = group is input
  input  logic             od_sel,
  input  logic             uart_tx_en,
  input  logic             uart_txd,
  input  logic [NGRP-1:0]  pullup_cfg,
  output logic [WIDTH-1:0] pin_is_out,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_od,
  output logic [WIDTH-1:0] pad_pu
);
  logic [WIDTH-1:0] pin_val;
  logic [WIDTH-1:0] out_nx;
  logic [WIDTH-1:0] oe_nx;
  logic [WIDTH-1:0] pu_nx;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    localparam int G = i / GROUP_W;
    if (i == WIDTH-1) begin : g_alt
      assign pin_val[i] = uart_tx_en ? uart_txd : data_q[i];
    end else begin : g_plain
      assign pin_val[i] = data_q[i];
    end
    assign pin_is_out[i] = ~grp_in[G];
    assign pu_nx[i]      = pullup_cfg[G];
    assign out_nx[i]     = od_sel ? 1'b0 : pin_val[i];
    assign oe_nx[i]      = pin_is_out[i] & (od_sel ? ~pin_val[i] : 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
      pad_od  <= '0;
      pad_pu  <= '0;
    end else begin
      pad_out <= out_nx;
      pad_oe  <= oe_nx;
      pad_od  <= {WIDTH{od_sel}};
      pad_pu  <= pu_nx;
    end
  end
endmodule

// File: rtl/nibble_gpio_port.sv
module nibble_gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int NGRP        = WIDTH / GROUP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_recover,
  input  logic             reg_we,
  input  logic             reg_sel,
  input  logic [WIDTH-1:0] reg_wdata,
  output logic [WIDTH-1:0] reg_rdata,
  input  logic             uart_tx_en,
  input  logic             uart_txd,
  input  logic [NGRP-1:0]  pullup_cfg,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_od,
  output logic [WIDTH-1:0] pad_pu
);
  reg_sel_e         sel;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] mode_q;
  logic [WIDTH-1:0] sync_q;
  logic [WIDTH-1:0] pin_is_out;
  logic [WIDTH-1:0] port_rd;

  assign sel = reg_sel_e'(reg_sel);

  gpio_port_regs #(.WIDTH(WIDTH), .NGRP(NGRP)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .stop_recover (stop_recover),
    .we           (reg_we),
    .sel          (sel),
    .wdata        (reg_wdata),
    .data_q       (data_q),
    .mode_q       (mode_q)
  );

  gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (sync_q)
  );

  gpio_port_drive #(.WIDTH(WIDTH), .NGRP(NGRP)) u_drive (
    .clk        (clk),
    .rst        (rst),
    .data_q     (data_q),
    .grp_in     (mode_q[DIR_LSB +: NGRP]),
    .od_sel     (mode_q[OD_BIT]),
    .uart_tx_en (uart_tx_en),
    .uart_txd   (uart_txd),
    .pullup_cfg (pullup_cfg),
    .pin_is_out (pin_is_out),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .pad_od     (pad_od),
    .pad_pu     (pad_pu)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_rd
    assign port_rd[i] = pin_is_out[i] ? data_q[i] : sync_q[i];
  end

  assign reg_rdata = (sel == SEL_MODE) ? mode_q : port_rd;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             stop_recover,
  input logic             uart_tx_en,
  input logic             uart_txd,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_od
);
  localparam int NGRP = WIDTH / GROUP_W;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_od == '0));

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assert_group_uniform_R2: assert property (@(posedge clk) disable iff (rst)
      !pad_od[0] |-> (pad_oe[g*GROUP_W +: GROUP_W] == '0 ||
                      pad_oe[g*GROUP_W +: GROUP_W] == {GROUP_W{1'b1}}));
  end

  assert_od_uniform_R3: assert property (@(posedge clk) disable iff (rst)
    (pad_od == '0 || pad_od == '1));

  assert_od_never_high_R3: assert property (@(posedge clk) disable iff (rst)
    pad_od[0] |-> pad_out == '0);

  assert_tx_on_pin_R5: assert property (@(posedge clk) disable iff (rst)
    uart_tx_en |=> (pad_od[0] || pad_out[WIDTH-1] == $past(uart_txd)));

  assert_stop_release_R7: assert property (@(posedge clk) disable iff (rst)
    stop_recover |=> ##1 pad_oe == '0);
endmodule

bind nibble_gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .stop_recover (stop_recover),
  .uart_tx_en   (uart_tx_en),
  .uart_txd     (uart_txd),
  .pad_out      (pad_out),
  .pad_oe       (pad_oe),
  .pad_od       (pad_od)
);

// File: tb/sim_nibble_gpio_port.sv
module sim_nibble_gpio_port;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       stop_recover = 1'b0;
  logic       reg_we = 1'b0;
  logic       reg_sel = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       uart_tx_en = 1'b0;
  logic       uart_txd = 1'b0;
  logic [1:0] pullup_cfg = '0;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe, pad_od, pad_pu;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  nibble_gpio_port u0 (
    .clk(clk), .rst(rst), .stop_recover(stop_recover),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .uart_tx_en(uart_tx_en), .uart_txd(uart_txd),
    .pullup_cfg(pullup_cfg), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_od(pad_od), .pad_pu(pad_pu)
  );

  typedef struct packed {
    logic [7:0] mode;
    logic [7:0] data;
    logic [7:0] pin;
    logic       txen;
    logic       txd;
    logic [7:0] e_out;
    logic [7:0] e_oe;
    logic [7:0] e_od;
    logic [7:0] e_rd;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'hA5, 8'h3C, 1'b0, 1'b0, 8'hA5, 8'hFF, 8'h00, 8'hA5}, // R2 R4 both out
    '{8'h60, 8'h5A, 8'h3C, 1'b0, 1'b0, 8'h5A, 8'h00, 8'h00, 8'h3C}, // R2 R8 both in
    '{8'h40, 8'h96, 8'hC3, 1'b0, 1'b0, 8'h96, 8'h0F, 8'h00, 8'hC6}, // R2 R8 low out
    '{8'h20, 8'h96, 8'hC3, 1'b0, 1'b0, 8'h96, 8'hF0, 8'h00, 8'h93}, // R2 R8 high out
    '{8'h04, 8'hF0, 8'h00, 1'b0, 1'b0, 8'h00, 8'h0F, 8'hFF, 8'hF0}, // R3 open drain
    '{8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 8'h80, 8'hFF, 8'h00, 8'h00}, // R5 txd=1
    '{8'h00, 8'h7F, 8'h00, 1'b1, 1'b0, 8'h7F, 8'hFF, 8'h00, 8'h7F}, // R5 txd=0
    '{8'h40, 8'h00, 8'hFF, 1'b1, 1'b1, 8'h80, 8'h0F, 8'h00, 8'hF0}, // R6 high in
    '{8'h04, 8'hFF, 8'h00, 1'b1, 1'b0, 8'h00, 8'h80, 8'hFF, 8'hFF}, // R3 R5 od tx
    '{8'h44, 8'h0A, 8'h55, 1'b0, 1'b0, 8'h00, 8'h05, 8'hFF, 8'h5A}  // R3 R8 mixed
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] val);
    reg_we    = 1'b1;
    reg_sel   = sel;
    reg_wdata = val;
    @(negedge clk);
    reg_we  = 1'b0;
    reg_sel = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 oe", pad_oe, 8'h00);
    chk("R1 out", pad_out, 8'h00);
    chk("R1 od", pad_od, 8'h00);
    chk("R1 pu", pad_pu, 8'h00);
    reg_sel = 1'b1;
    #0 chk("R1 mode", reg_rdata, 8'h60);
    reg_sel = 1'b0;
    wr(1'b1, 8'h00);
    @(negedge clk);
    chk("R1 latch", pad_out, 8'h00);

    // table walk
    for (int v = 0; v < NV; v++) begin
      wr(1'b1, VECS[v].mode);
      wr(1'b0, VECS[v].data);
      pad_in     = VECS[v].pin;
      uart_tx_en = VECS[v].txen;
      uart_txd   = VECS[v].txd;
      repeat (3) @(negedge clk);
      chk($sformatf("R2-vec%0d out", v), pad_out, VECS[v].e_out);
      chk($sformatf("R3-vec%0d oe", v), pad_oe, VECS[v].e_oe);
      chk($sformatf("R3-vec%0d od", v), pad_od, VECS[v].e_od);
      chk($sformatf("R8-vec%0d rd", v), reg_rdata, VECS[v].e_rd);
    end
    uart_tx_en = 1'b0;
    uart_txd   = 1'b0;

    // R9 write while input is retained
    wr(1'b1, 8'h60);
    wr(1'b0, 8'h3C);
    @(negedge clk);
    chk("R9 oe while input", pad_oe, 8'h00);
    wr(1'b1, 8'h00);
    @(negedge clk);
    chk("R9 out after switch", pad_out, 8'h3C);
    chk("R9 oe after switch", pad_oe, 8'hFF);

    // R8 synchronizer latency
    wr(1'b1, 8'h60);
    pad_in = 8'h00;
    repeat (3) @(negedge clk);
    pad_in = 8'hA5;
    @(negedge clk);
    chk("R8 sync after 1", reg_rdata, 8'h00);
    @(negedge clk);
    chk("R8 sync after 2", reg_rdata, 8'hA5);

    // R10 pull-up per group
    pullup_cfg = 2'b01;
    @(negedge clk);
    chk("R10 pu low", pad_pu, 8'h0F);
    pullup_cfg = 2'b10;
    @(negedge clk);
    chk("R10 pu high", pad_pu, 8'hF0);

    // R7 stop recovery alone keeps other bits and latch
    wr(1'b1, 8'h84);
    wr(1'b0, 8'h00);
    @(negedge clk);
    chk("R7 pre oe", pad_oe, 8'hFF);
    stop_recover = 1'b1;
    @(negedge clk);
    stop_recover = 1'b0;
    reg_sel = 1'b1;
    #0 chk("R7 mode kept", reg_rdata, 8'hE4);
    reg_sel = 1'b0;
    @(negedge clk);
    chk("R7 oe released", pad_oe, 8'h00);

    // R7 collision: mode write and stop recovery same cycle
    wr(1'b1, 8'h00);
    @(negedge clk);
    chk("R7 collide pre oe", pad_oe, 8'hFF);
    stop_recover = 1'b1;
    wr(1'b1, 8'h04);
    stop_recover = 1'b0;
    reg_sel = 1'b1;
    #0 chk("R7 collide mode", reg_rdata, 8'h64);
    chk("R11 mode readback", reg_rdata, 8'h64);
    reg_sel = 1'b0;
    @(negedge clk);
    chk("R7 collide oe", pad_oe, 8'h00);
    chk("R7 collide od", pad_od, 8'hFF);

    // R6 tx with upper group input: enable stays low
    wr(1'b1, 8'h40);
    uart_tx_en = 1'b1;
    uart_txd   = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 pin7 oe", {7'd0, pad_oe[7]}, 8'h00);
    uart_tx_en = 1'b0;

    // R11 outputs lag register write by one clock
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h11);
    chk("R11 before edge", pad_out, 8'h00);
    @(negedge clk);
    chk("R11 after edge", pad_out, 8'h11);

    finish_run();
  end
endmodule